// File: doc/BRIEF.md
# Serial Byte Transmitter with End-of-Burst Interrupt

This block sends bytes on an asynchronous serial line. A single-byte holding register sits in front of a shift register. The holding register lets the host stage the next byte while the current frame is still on the wire. A baud tick input sets the pace of the line, with one tick for each bit time. Two completion events are reported separately. The first says the holding register has been emptied into the shifter and can take another byte. The second says the line has gone quiet: the last stop bit has ended and nothing is waiting. A host can therefore stream a burst on the first event and take a single interrupt at the end of the burst, at the moment it is safe to turn a half-duplex bus around.

The block drives a transceiver enable output. This output is raised when a frame starts from idle and dropped in the same cycle that the end-of-burst flag is set. A loopback listen mode feeds the outgoing bit stream into a small internal deserializer, so that each sent byte comes back as an echo with a flag of its own. Every flag can be cleared with write-one-to-clear and has its own interrupt enable. The interrupt output is the OR of the enabled flags.

Top module: `uart_tx_burst`

## Requirements
- R1: After reset, txd is 1, drv_en is 0, busy is 0, flags is 000 and irq is 0.
- R2: A frame is one 0 start bit, then 8 data bits least significant first, then one 1 stop bit. Each bit lasts one baud tick interval, so a lone frame takes 10 intervals from its load until flags bit 1 is set.
- R3: A byte written while the shifter is idle is not loaded before the next baud tick. At that tick it is loaded, busy goes to 1 and flags bit 0 (buffer empty) is set.
- R4: A write while the holding register already holds a byte is dropped, and that byte never appears on txd.
- R5: When a byte is waiting as a stop bit ends, its start bit follows at once. Flags bit 0 is set again, busy stays 1 and flags bit 1 is not set.
- R6: Flags bit 1 (transmit complete) is set only at the tick that ends a stop bit with the holding register empty. In that same cycle busy and drv_en fall to 0.
- R7: drv_en is 1 whenever busy is 1, from the first load until transmit complete.
- R8: With listen_en at 1, each sent byte appears on echo_data, and flags bit 2 (echo) is set at the tick that ends its stop bit.
- R9: With listen_en at 0, flags bit 2 is never set.
- R10: Writing 1 to a bit of flag_clr clears that flag. A 0 leaves it unchanged.
- R11: irq is 1 exactly when some flag bit is 1 and its irq_en bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| listen_en | input | 1 | Loop the output stream into the echo deserializer |
| flag_clr | input | 3 | Write-one-to-clear for flags |
| irq_en | input | 3 | Interrupt enable per flag |
| txd | output | 1 | Serial output, idles high |
| drv_en | output | 1 | Transceiver driver enable |
| busy | output | 1 | Frame in progress |
| flags | output | 3 | bit0 buffer empty, bit1 transmit complete, bit2 echo received |
| irq | output | 1 | OR of enabled flags |
| echo_data | output | DATA_W | Last echoed byte |

## Verification
The bench builds the block with its default DATA_W of 8. It generates a baud tick every 8 clocks, so a frame lasts 80 cycles. That length is short enough to run single frames, a three-byte burst with a dropped write, and looped-back frames in both listen settings. The 80-cycle figure also serves as an exact completion count.

The tick spacing makes the idle-to-load wait visible. It also places the write that is meant to be dropped inside a frame, while the holding register is occupied.

// File: rtl/utx_pkg.sv
package utx_pkg;
    localparam int NFLAG     = 3;
    localparam int FLG_EMPTY = 0;
    localparam int FLG_DONE  = 1;
    localparam int FLG_ECHO  = 2;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_START,
        SH_DATA,
        SH_STOP
    } sh_state_t;

    typedef enum logic [1:0] {
        EC_IDLE,
        EC_DATA,
        EC_STOP
    } ec_state_t;
endpackage

// File: rtl/utx_hold.sv
module utx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_valid && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              done,
    output logic              txd,
    output logic              busy,
    output logic              drv_en
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    sh_state_t         state, state_nx;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    // Next-state logic
    always_comb begin
        state_nx = state;
        take     = 1'b0;
        done     = 1'b0;
        unique case (state)
            SH_IDLE: begin
                if (baud_tick && hold_full) begin
                    state_nx = SH_START;
                    take     = 1'b1;
                end
            end
            SH_START: begin
                if (baud_tick) state_nx = SH_DATA;
            end
            SH_DATA: begin
                if (baud_tick && cnt == LAST) state_nx = SH_STOP;
            end
            SH_STOP: begin
                if (baud_tick) begin
                    if (hold_full) begin
                        state_nx = SH_START;
                        take     = 1'b1;
                    end else begin
                        state_nx = SH_IDLE;
                        done     = 1'b1;
                    end
                end
            end
        endcase
    end

    // State register with datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= SH_IDLE;
            shreg  <= '0;
            cnt    <= '0;
            drv_en <= 1'b0;
        end else begin
            state <= state_nx;
            if (take) begin
                shreg  <= hold_data;
                cnt    <= '0;
                drv_en <= 1'b1;
            end else if (done) begin
                drv_en <= 1'b0;
            end
            if (state == SH_DATA && baud_tick) begin
                shreg <= shreg >> 1;
                cnt   <= cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            SH_IDLE:  txd = 1'b1;
            SH_START: txd = 1'b0;
            SH_DATA:  txd = shreg[0];
            SH_STOP:  txd = 1'b1;
        endcase
        busy = (state != SH_IDLE);
    end
endmodule

// File: rtl/utx_echo_rx.sv
module utx_echo_rx
    import utx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              listen_en,
    input  logic              baud_tick,
    input  logic              line,
    output logic              got,
    output logic [DATA_W-1:0] echo_data
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    ec_state_t         state, state_nx;
    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            EC_IDLE: if (baud_tick && !line) state_nx = EC_DATA;
            EC_DATA: if (baud_tick && cnt == LAST) state_nx = EC_STOP;
            EC_STOP: if (baud_tick) state_nx = EC_IDLE;
        endcase
        if (!listen_en) state_nx = EC_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= EC_IDLE;
            sh        <= '0;
            cnt       <= '0;
            echo_data <= '0;
        end else begin
            state <= state_nx;
            if (state == EC_IDLE) cnt <= '0;
            if (state == EC_DATA && baud_tick) begin
                sh  <= {line, sh[DATA_W-1:1]};
                cnt <= cnt + 1'b1;
            end
            if (got) echo_data <= sh;
        end
    end

    always_comb begin
        got = listen_en && baud_tick && (state == EC_STOP) && line;
    end
endmodule

// File: rtl/utx_flags.sv
module utx_flags
    import utx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    input  logic [NFLAG-1:0] en,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= set[i] | (flags[i] & ~clr[i]);
        end
    end

    always_comb irq = |(flags & en);
endmodule

// File: rtl/uart_tx_burst.sv
module uart_tx_burst
    import utx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    input  logic              listen_en,
    input  logic [NFLAG-1:0]  flag_clr,
    input  logic [NFLAG-1:0]  irq_en,
    output logic              txd,
    output logic              drv_en,
    output logic              busy,
    output logic [NFLAG-1:0]  flags,
    output logic              irq,
    output logic [DATA_W-1:0] echo_data
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take, done, got;
    logic [NFLAG-1:0]  set_v;

    utx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .take(take), .full(hold_full), .data(hold_data)
    );

    utx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .hold_full(hold_full), .hold_data(hold_data),
        .take(take), .done(done), .txd(txd), .busy(busy), .drv_en(drv_en)
    );

    utx_echo_rx #(.DATA_W(DATA_W)) u_echo (
        .clk(clk), .rst_n(rst_n), .listen_en(listen_en), .baud_tick(baud_tick),
        .line(txd), .got(got), .echo_data(echo_data)
    );

    always_comb begin
        set_v            = '0;
        set_v[FLG_EMPTY] = take;
        set_v[FLG_DONE]  = done;
        set_v[FLG_ECHO]  = got;
    end

    utx_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set(set_v), .clr(flag_clr), .en(irq_en),
        .flags(flags), .irq(irq)
    );
endmodule

// File: rtl/utx_checker.sv
module utx_checker
    import utx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             txd,
    input logic             drv_en,
    input logic             busy,
    input logic             listen_en,
    input logic [NFLAG-1:0] flags
);
    a_r6_done_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_DONE]) |-> (!busy && !drv_en));

    a_r6_de_drop_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> flags[FLG_DONE]);

    a_r7_busy_needs_de: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> drv_en);

    a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    a_r3_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> flags[FLG_EMPTY]);

    a_r9_no_echo_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!listen_en && !flags[FLG_ECHO]) |=> !flags[FLG_ECHO]);
endmodule

bind uart_tx_burst utx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .drv_en(drv_en), .busy(busy),
    .listen_en(listen_en), .flags(flags)
);

// File: tb/sim_uart_tx_burst.sv
module sim_uart_tx_burst;
    localparam int DW  = 8;
    localparam int DIV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          baud_tick = 1'b0;
    logic          listen_en = 1'b0;
    logic [2:0]    flag_clr = '0;
    logic [2:0]    irq_en = '0;
    logic          txd, drv_en, busy, irq;
    logic [2:0]    flags;
    logic [DW-1:0] echo_data;

    int errors = 0;
    int checks = 0;
    int frames = 0;
    int tcnt = 0;
    logic [DW-1:0] exp_q[$];

    always #4 clk = ~clk;

    uart_tx_burst #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .baud_tick(baud_tick), .listen_en(listen_en), .flag_clr(flag_clr),
        .irq_en(irq_en), .txd(txd), .drv_en(drv_en), .busy(busy),
        .flags(flags), .irq(irq), .echo_data(echo_data)
    );

    always @(negedge clk) begin
        tcnt      <= (tcnt == DIV - 1) ? 0 : tcnt + 1;
        baud_tick <= (tcnt == DIV - 2);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic send(input logic [DW-1:0] b, input bit accept);
        wr_valid = 1'b1;
        wr_data  = b;
        if (accept) exp_q.push_back(b);
        step();
        wr_valid = 1'b0;
    endtask

    task automatic clear(input logic [2:0] m);
        flag_clr = m;
        step();
        flag_clr = '0;
    endtask

    // wait for completion; return cycles, check drv_en high just before
    task automatic wait_done(output int n);
        logic de_prev;
        n = 0;
        de_prev = drv_en;
        while (!flags[1] && n < 2000) begin
            de_prev = drv_en;
            step();
            n++;
        end
        chk(de_prev == 1'b1 && drv_en == 1'b0 && busy == 1'b0, "R6", {drv_en, busy}, 0);
    endtask

    // Monitor: decode txd, compare against scoreboard queue
    initial begin
        logic prev;
        logic [DW-1:0] got;
        prev = 1'b1;
        forever begin
            step();
            if (prev && !txd) begin
                repeat (3) step();
                chk(txd == 1'b0, "R2 start", txd, 0);
                for (int i = 0; i < DW; i++) begin
                    repeat (DIV) step();
                    got[i] = txd;
                end
                repeat (DIV) step();
                chk(txd == 1'b1, "R2 stop", txd, 1);
                frames++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected frame", got, 0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(got == e, "R2 data", got, e);
                end
            end
            prev = txd;
        end
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        bit ok;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1
        chk(txd == 1 && drv_en == 0 && busy == 0 && flags == 0 && irq == 0,
            "R1", {txd, drv_en, busy, flags, irq}, 7'b1000000);

        // R3: idle write waits for tick
        while (baud_tick) step();
        repeat (2) step();
        send(8'hA5, 1);
        while (!baud_tick) begin
            chk(busy == 0, "R3 early", busy, 0);
            step();
        end
        step();
        chk(busy == 1 && flags[0] == 1 && drv_en == 1, "R3 load", {busy, flags[0], drv_en}, 3'b111);
        // R2 length, R6, R7
        wait_done(n);
        chk(n == 10 * DIV, "R2 length", n, 10 * DIV);
        chk(flags[1] == 1, "R6 done", flags, 3'b011);
        repeat (6) step();

        // R10: clear only done
        clear(3'b010);
        chk(flags == 3'b001, "R10 partial", flags, 3'b001);
        clear(3'b001);
        chk(flags == 3'b000, "R10 clear", flags, 0);

        // R4, R5 burst
        frames = 0;
        send(8'h3C, 1);
        while (!flags[0]) step();
        flag_clr = 3'b001;
        send(8'h81, 1);
        flag_clr = '0;
        send(8'hFF, 0);          // holding full: dropped (R4)
        ok = 1;
        n = 0;
        while (!flags[0] && n < 200) begin
            if (!busy || flags[1]) ok = 0;
            step();
            n++;
        end
        chk(ok && flags[1] == 0 && busy == 1, "R5 back-to-back", {flags, busy}, 4'b0011);
        flag_clr = 3'b001;
        send(8'h5A, 1);
        flag_clr = '0;
        ok = 1;
        while (!flags[1] && n < 2000) begin
            if (!busy) ok = 0;
            step();
            n++;
        end
        chk(ok, "R5 busy held", ok, 1);
        chk(frames == 3, "R4 frame count", frames, 3);
        chk(exp_q.size() == 0, "R4 queue", exp_q.size(), 0);
        repeat (6) step();
        clear(3'b111);

        // R8 listen
        listen_en = 1'b1;
        send(8'hC3, 1);
        wait_done(n);
        chk(flags[2] == 1, "R8 echo flag", flags, 3'b111);
        chk(echo_data == 8'hC3, "R8 echo data", echo_data, 8'hC3);
        repeat (6) step();
        clear(3'b111);

        // R9 listen off
        listen_en = 1'b0;
        send(8'h69, 1);
        wait_done(n);
        repeat (DIV) step();
        chk(flags[2] == 0, "R9 no echo", flags, 3'b011);
        chk(echo_data == 8'hC3, "R9 echo held", echo_data, 8'hC3);

        // R11 irq: flags now 011
        irq_en = 3'b000; step();
        chk(irq == 0, "R11 none", irq, 0);
        irq_en = 3'b100; step();
        chk(irq == 0, "R11 masked", irq, 0);
        irq_en = 3'b010; step();
        chk(irq == 1, "R11 done", irq, 1);
        clear(3'b010);
        chk(irq == 0, "R11 cleared", irq, 0);
        irq_en = 3'b001; step();
        chk(irq == 1, "R11 empty", irq, 1);

        repeat (4) step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule